// File: doc/BRIEF.md
# Motor command output formatter

This block takes a signed two's-complement motor command and presents it to the drive electronics in one of three formats. A two-bit mode input picks the format. The first is a latched 8-bit offset-binary word for a flow-through converter. The second is a 12-bit offset-binary word sent as two 6-bit halves over the low bits of the same bus, with a strobe for an external holding latch and a strobe for the converter's load input. The third is a sign line plus an 8-bit pulse-width magnitude.

A one-cycle `cmd_load` strobe offers a new command. The block adopts that command only at a safe boundary of the current format, so a half-sent word or a partly generated pulse period never mixes two commands. Until then the most recent offer is held, and a later offer replaces an earlier one. Multiplex phases and PWM counts advance only on clock cycles where `tick` is high.

The controller has four states. `PAR` drives the parallel byte and adopts a command every cycle. `MUX_HI` drives the upper half and moves to `MUX_LO` on a tick. `MUX_LO` drives the lower half and returns to `MUX_HI` on a tick; a command is adopted on that return. `PWM` counts ticks and adopts a command when the count wraps. When the mode input names a different format family, the controller goes directly to that family's entry state (`PAR`, `MUX_HI`, or `PWM` with count 0) and adopts a command in that same transition.

Top module: `motor_out_fmt`

## Requirements
- R1: During and right after reset the outputs are `dac_bus`=0x80, both strobes 0, `pwm_mag`=0, `pwm_sign`=0, and the state is `PAR` with a held command of 0.
- R2: With mode 2'b00 or 2'b11 (`PAR`), `dac_bus` equals bits [11:4] of the command with bit 7 inverted. It takes effect on the clock edge after the `cmd_load` edge.
- R3: Zero torque is mid-scale. A zero command gives 0x80 on the byte. On the 12-bit path it gives 0x800, which is upper half 0x20 and lower half 0x00.
- R4: With mode 2'b01, `dac_bus[5:0]` carries offset-code bits [11:6] in `MUX_HI` and bits [5:0] in `MUX_LO`, and `dac_bus[7:6]` is 0. Each tick moves to the other phase.
- R5: `hi_latch_stb` is high exactly in `MUX_HI` cycles that have `tick` high. `dac_load_stb` is high exactly in `MUX_LO` cycles that have `tick` high. The two strobes are never high together.
- R6: In the 12-bit mode a command is adopted only on the `MUX_LO` to `MUX_HI` step, so both halves come from the same command.
- R7: With mode 2'b10, `pwm_sign` is 1 when the held command is negative. The magnitude is min(|command| >> 3, 255). Outside PWM the sign is 0.
- R8: A PWM period is 256 ticks. `pwm_mag` is high while the count (0..255) is below the magnitude, and a magnitude of 255 keeps it high for the whole period. In PWM, `dac_bus` and both strobes are 0.
- R9: In PWM a command is adopted only on a tick where the count is 255.
- R10: A change of mode family enters that family's first state at once, with the PWM count at 0, and adopts the newest command.
- R11: When several `cmd_load` strobes arrive between boundaries, the last one wins. A load on a boundary cycle is adopted on that edge.
- R12: While `tick` is low, the multiplex phase and the PWM count hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | 00/11 parallel byte, 01 multiplexed 12-bit, 10 PWM |
| tick | input | 1 | Advances multiplex phase or PWM count |
| cmd_load | input | 1 | Offers `cmd` as the new command |
| cmd | input | 12 | Signed two's-complement command |
| dac_bus | output | 8 | Parallel byte or 6-bit half (zero-extended) |
| hi_latch_stb | output | 1 | Capture strobe for the external upper-half latch |
| dac_load_stb | output | 1 | Converter load strobe for the full 12-bit word |
| pwm_mag | output | 1 | PWM magnitude pulse |
| pwm_sign | output | 1 | PWM direction, 1 = negative |

## Verification
A `cmd_load` in `PAR` shows on `dac_bus` one clock edge later. In the 12-bit and PWM formats the command first appears in the cycle after the adopting edge (the edge that leaves `MUX_LO` on a tick, or the edge where the count wraps). The strobes and the PWM compare are combinational from the registered state and the present `tick`, so they are due in the same cycle as the tick. The bench drives inputs on the falling edge and samples 1 ns later. Its model advances on the rising edge, so every output is compared in the cycle where it is due, including the strobes that depend on the tick.

// File: rtl/mfmt_pkg.sv
package mfmt_pkg;

    localparam logic [1:0] MODE_PAR8  = 2'b00;
    localparam logic [1:0] MODE_MUX12 = 2'b01;
    localparam logic [1:0] MODE_PWM8  = 2'b10;

    typedef enum logic [1:0] {
        ST_PAR = 2'd0,
        ST_HI  = 2'd1,
        ST_LO  = 2'd2,
        ST_PWM = 2'd3
    } fmt_state_e;

    // First state of the format family a mode selects
    function automatic fmt_state_e entry_state(input logic [1:0] m);
        fmt_state_e s;
        case (m)
            MODE_MUX12: s = ST_HI;
            MODE_PWM8:  s = ST_PWM;
            default:    s = ST_PAR;
        endcase
        return s;
    endfunction

    // True when state s already belongs to the family of mode m
    function automatic logic in_family(input fmt_state_e s, input logic [1:0] m);
        fmt_state_e e;
        e = entry_state(m);
        if (e == ST_HI)
            return (s == ST_HI) || (s == ST_LO);
        return s == e;
    endfunction

endpackage

// File: rtl/mfmt_seq.sv
module mfmt_seq
    import mfmt_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [1:0]       mode,
    output fmt_state_e       state,
    output logic [CNT_W-1:0] cnt,
    output logic             take
);

    localparam logic [CNT_W-1:0] CNT_LAST = '1;

    fmt_state_e       state_d;
    logic [CNT_W-1:0] cnt_d;

    always_comb begin
        state_d = state;
        cnt_d   = cnt;
        take    = 1'b0;
        if (!in_family(state, mode)) begin
            state_d = entry_state(mode);
            cnt_d   = '0;
            take    = 1'b1;
        end else begin
            unique case (state)
                ST_PAR: take = 1'b1;
                ST_HI: begin
                    if (tick) state_d = ST_LO;
                end
                ST_LO: begin
                    if (tick) begin
                        state_d = ST_HI;
                        take    = 1'b1;
                    end
                end
                ST_PWM: begin
                    if (tick) begin
                        if (cnt == CNT_LAST) begin
                            cnt_d = '0;
                            take  = 1'b1;
                        end else begin
                            cnt_d = cnt + 1'b1;
                        end
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_PAR;
            cnt   <= '0;
        end else begin
            state <= state_d;
            cnt   <= cnt_d;
        end
    end

    // R12
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PWM && $past(state) == ST_PWM && !$past(tick)) |-> $stable(cnt));

    // R12
    phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == ST_HI && !$past(tick) && $past(in_family(state, mode))) |-> state == ST_HI);

endmodule

// File: rtl/mfmt_cmd_hold.sv
module mfmt_cmd_hold #(
    parameter int CMD_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take,
    input  logic             load,
    input  logic [CMD_W-1:0] cmd_in,
    output logic [CMD_W-1:0] act
);

    logic [CMD_W-1:0] pend;
    logic             pend_vld;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act      <= '0;
            pend     <= '0;
            pend_vld <= 1'b0;
        end else if (take) begin
            if (load)
                act <= cmd_in;
            else if (pend_vld)
                act <= pend;
            pend_vld <= 1'b0;
        end else if (load) begin
            pend     <= cmd_in;
            pend_vld <= 1'b1;
        end
    end

endmodule

// File: rtl/mfmt_encode.sv
module mfmt_encode
    import mfmt_pkg::*;
#(
    parameter int CMD_W  = 12,
    parameter int PAR_W  = 8,
    parameter int HALF_W = 6,
    parameter int MAG_W  = 8
) (
    input  fmt_state_e       state,
    input  logic [CMD_W-1:0] act,
    input  logic [MAG_W-1:0] cnt,
    input  logic             tick,
    output logic [PAR_W-1:0] bus,
    output logic             hi_stb,
    output logic             ld_stb,
    output logic             mag_out,
    output logic             sign_out,
    output logic [MAG_W-1:0] mag
);

    localparam int               FULL_W    = 2 * HALF_W;
    localparam int               MAG_SHIFT = CMD_W - MAG_W - 1;
    localparam logic [MAG_W-1:0] MAG_MAX   = '1;
    localparam logic [CMD_W:0]   MAG_LIM   = (CMD_W + 1)'({MAG_W{1'b1}});

    logic [FULL_W-1:0] ofs;
    logic [CMD_W:0]    ext;
    logic [CMD_W:0]    absv;
    logic [CMD_W:0]    shv;

    // Offset binary: flip the sign bit of the top FULL_W command bits
    assign ofs = {~act[CMD_W-1], act[CMD_W-2 -: FULL_W-1]};

    always_comb begin
        ext  = {act[CMD_W-1], act};
        absv = act[CMD_W-1] ? (~ext + 1'b1) : ext;
        shv  = absv >> MAG_SHIFT;
        mag  = (shv > MAG_LIM) ? MAG_MAX : shv[MAG_W-1:0];
    end

    always_comb begin
        bus      = '0;
        hi_stb   = 1'b0;
        ld_stb   = 1'b0;
        mag_out  = 1'b0;
        sign_out = 1'b0;
        unique case (state)
            ST_PAR: bus = ofs[FULL_W-1 -: PAR_W];
            ST_HI: begin
                bus    = PAR_W'(ofs[FULL_W-1 -: HALF_W]);
                hi_stb = tick;
            end
            ST_LO: begin
                bus    = PAR_W'(ofs[HALF_W-1:0]);
                ld_stb = tick;
            end
            ST_PWM: begin
                sign_out = act[CMD_W-1];
                mag_out  = (mag == MAG_MAX) || (cnt < mag);
            end
        endcase
    end

endmodule

// File: rtl/motor_out_fmt.sv
module motor_out_fmt
    import mfmt_pkg::*;
#(
    parameter int CMD_W  = 12,
    parameter int PAR_W  = 8,
    parameter int HALF_W = 6,
    parameter int MAG_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       mode,
    input  logic             tick,
    input  logic             cmd_load,
    input  logic [CMD_W-1:0] cmd,
    output logic [PAR_W-1:0] dac_bus,
    output logic             hi_latch_stb,
    output logic             dac_load_stb,
    output logic             pwm_mag,
    output logic             pwm_sign
);

    localparam logic [PAR_W-1:0] MID_BYTE = PAR_W'(1) << (PAR_W - 1);
    localparam logic [MAG_W-1:0] CNT_LAST = '1;
    localparam logic [MAG_W-1:0] MAG_FULL = '1;

    fmt_state_e       state;
    logic [MAG_W-1:0] cnt;
    logic             take;
    logic [CMD_W-1:0] act;
    logic [MAG_W-1:0] mag;

    mfmt_seq #(.CNT_W(MAG_W)) u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .mode  (mode),
        .state (state),
        .cnt   (cnt),
        .take  (take)
    );

    mfmt_cmd_hold #(.CMD_W(CMD_W)) u_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .take   (take),
        .load   (cmd_load),
        .cmd_in (cmd),
        .act    (act)
    );

    mfmt_encode #(
        .CMD_W  (CMD_W),
        .PAR_W  (PAR_W),
        .HALF_W (HALF_W),
        .MAG_W  (MAG_W)
    ) u_enc (
        .state    (state),
        .act      (act),
        .cnt      (cnt),
        .tick     (tick),
        .bus      (dac_bus),
        .hi_stb   (hi_latch_stb),
        .ld_stb   (dac_load_stb),
        .mag_out  (pwm_mag),
        .sign_out (pwm_sign),
        .mag      (mag)
    );

    // R3
    zero_mid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PAR && act == '0) |-> dac_bus == MID_BYTE);

    // R5
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(hi_latch_stb && dac_load_stb));

    // R6
    mux_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LO && $past(state) == ST_HI) |-> act == $past(act));

    // R9
    pwm_sign_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PWM && $past(state) == ST_PWM && $past(cnt) != CNT_LAST) |-> $stable(pwm_sign));

    // R8
    pwm_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PWM && mag == MAG_FULL) |-> pwm_mag);

    // R11
    newest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(take) && $past(cmd_load)) |-> act == $past(cmd));

endmodule

// File: tb/tb_motor_out_fmt.sv
module tb_motor_out_fmt;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  mode = 2'b00;
    logic        tick = 1'b0;
    logic        cmd_load = 1'b0;
    logic [11:0] cmd = '0;
    logic [7:0]  dac_bus;
    logic        hi_latch_stb, dac_load_stb, pwm_mag, pwm_sign;

    motor_out_fmt dut (
        .clk(clk), .rst_n(rst_n), .mode(mode), .tick(tick),
        .cmd_load(cmd_load), .cmd(cmd), .dac_bus(dac_bus),
        .hi_latch_stb(hi_latch_stb), .dac_load_stb(dac_load_stb),
        .pwm_mag(pwm_mag), .pwm_sign(pwm_sign)
    );

    always #4 clk = ~clk;

    int    n_vec = 0;
    int    n_bad = 0;
    string cur_req = "R1";

    // Behavioural model: st 0=parallel 1=upper half 2=lower half 3=pwm
    int m_st = 0, m_act = 0, m_pend = 0, m_pv = 0, m_cnt = 0;

    function automatic int fam_of_mode(input logic [1:0] m);
        return (m == 2'b01) ? 1 : (m == 2'b10) ? 3 : 0;
    endfunction

    always @(posedge clk) begin
        int tk;
        int want;
        int cur;
        if (!rst_n) begin
            m_st = 0; m_act = 0; m_pend = 0; m_pv = 0; m_cnt = 0;
        end else begin
            tk = 0;
            want = fam_of_mode(mode);
            cur = (m_st == 2) ? 1 : m_st;
            if (cur != want) begin
                m_st = want; m_cnt = 0; tk = 1;
            end else if (m_st == 0) begin
                tk = 1;
            end else if (m_st == 1) begin
                if (tick) m_st = 2;
            end else if (m_st == 2) begin
                if (tick) begin m_st = 1; tk = 1; end
            end else if (tick) begin
                if (m_cnt == 255) begin m_cnt = 0; tk = 1; end
                else m_cnt = m_cnt + 1;
            end
            if (tk) begin
                if (cmd_load) m_act = int'(cmd);
                else if (m_pv) m_act = m_pend;
                m_pv = 0;
            end else if (cmd_load) begin
                m_pend = int'(cmd); m_pv = 1;
            end
        end
    end

    task automatic chk(input string req, input string what, input int got, input int exp);
        n_vec++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
        end
    endtask

    task automatic compare_all();
        int ofs, sv, mg, e_bus, e_hi, e_ld, e_mag, e_sgn;
        ofs = m_act ^ 12'h800;
        sv = (m_act >= 2048) ? m_act - 4096 : m_act;
        mg = ((sv < 0) ? -sv : sv) >> 3;
        if (mg > 255) mg = 255;
        e_bus = (m_st == 0) ? (ofs >> 4) : (m_st == 1) ? ((ofs >> 6) & 63) :
                (m_st == 2) ? (ofs & 63) : 0;
        e_hi  = (m_st == 1 && tick) ? 1 : 0;
        e_ld  = (m_st == 2 && tick) ? 1 : 0;
        e_sgn = (m_st == 3 && sv < 0) ? 1 : 0;
        e_mag = (m_st == 3 && (mg == 255 || m_cnt < mg)) ? 1 : 0;
        chk(cur_req, "dac_bus", int'(dac_bus), e_bus);
        chk(cur_req, "hi_latch_stb", int'(hi_latch_stb), e_hi);
        chk(cur_req, "dac_load_stb", int'(dac_load_stb), e_ld);
        chk(cur_req, "pwm_sign", int'(pwm_sign), e_sgn);
        chk(cur_req, "pwm_mag", int'(pwm_mag), e_mag);
    endtask

    task automatic step(input logic t, input logic ld, input logic [11:0] c, input string req);
        @(negedge clk);
        tick = t; cmd_load = ld; cmd = c; cur_req = req;
        #1;
        compare_all();
    endtask

    task automatic idle(input int n, input int every, input string req);
        for (int i = 0; i < n; i++) step((i % every) == 0, 1'b0, 12'h000, req);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        #(8 * 150000);
        n_bad++;
        $display("FAIL watchdog: actual running expected done");
        finish_run();
    end

    initial begin
        bit seen;
        repeat (4) @(negedge clk);
        #1;
        // R1: reset values while reset is asserted
        chk("R1", "reset bus", int'(dac_bus), 8'h80);
        chk("R1", "reset strobes", int'({hi_latch_stb, dac_load_stb}), 0);
        chk("R1", "reset pwm", int'({pwm_sign, pwm_mag}), 0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1", "post-reset bus", int'(dac_bus), 8'h80);

        // R2: parallel byte, one edge after load
        mode = 2'b00;
        step(0, 1, 12'h7FF, "R2"); step(0, 0, 0, "R2");
        chk("R2", "byte 7FF", int'(dac_bus), 8'hFF);
        step(0, 1, 12'h800, "R2"); step(0, 0, 0, "R2");
        chk("R2", "byte 800", int'(dac_bus), 8'h00);
        step(0, 1, 12'h123, "R2"); step(1, 1, 12'hFF0, "R2"); idle(3, 1, "R2");
        // R3: zero in byte mode
        step(0, 1, 12'h000, "R3"); step(0, 0, 0, "R3");
        chk("R3", "byte zero", int'(dac_bus), 8'h80);
        mode = 2'b11;
        step(0, 1, 12'h456, "R2"); idle(3, 1, "R2");

        // R10 / R4 / R5: enter multiplexed mode
        mode = 2'b01;
        step(1, 1, 12'hA5C, "R10");
        for (int i = 0; i < 40; i++) step(1'b1, (i % 5) == 2, 12'(i * 97), "R4");
        // R12: sparse ticks hold the phase
        for (int i = 0; i < 45; i++) step((i % 3) == 0, (i % 7) == 1, 12'(i * 211 + 5), "R12");
        // R6: loads at every phase
        for (int i = 0; i < 30; i++) step((i % 2) == 0, 1'b1, 12'(i * 331), "R6");
        // R3: zero command on the 12-bit path
        step(1, 1, 12'h000, "R3"); idle(4, 1, "R3");
        seen = 0;
        for (int i = 0; i < 6 && !seen; i++) begin
            step(1, 0, 0, "R5");
            if (hi_latch_stb) begin
                seen = 1;
                chk("R3", "upper half of zero", int'(dac_bus), 8'h20);
                step(1, 0, 0, "R5");
                chk("R3", "lower half of zero", int'(dac_bus), 8'h00);
                chk("R5", "load strobe after upper", int'(dac_load_stb), 1);
            end
        end
        chk("R5", "upper strobe seen", int'(seen), 1);

        // R10: into PWM mid-cycle; R8 full scale
        mode = 2'b10;
        step(1, 1, 12'h7FF, "R10");
        idle(300, 1, "R8");
        step(1, 1, 12'hFF8, "R7"); idle(300, 1, "R7");
        step(1, 1, 12'h400, "R8"); idle(300, 1, "R8");
        // R9: mid-period load waits for the wrap
        idle(40, 1, "R9");
        step(1, 1, 12'hC00, "R9"); idle(300, 1, "R9");
        // R11: several loads, last wins
        idle(50, 1, "R11");
        step(1, 1, 12'h100, "R11"); step(1, 1, 12'h0F0, "R11"); step(1, 1, 12'hF00, "R11");
        idle(300, 1, "R11");
        // R12: ticks every other cycle
        idle(200, 2, "R12");
        // R10: family hops mid-period
        mode = 2'b01; step(1, 1, 12'h3C3, "R10"); idle(6, 1, "R10");
        mode = 2'b10; step(0, 1, 12'h9A0, "R10"); idle(20, 1, "R10");
        mode = 2'b00; step(0, 0, 0, "R10"); idle(3, 1, "R10");
        finish_run();
    end

endmodule